// File: doc/BRIEF.md
# Dual-Clock Read Buffer with Bypass Path

This block sits on the read side of a 64-bit memory error-correction unit. Corrected memory words arrive in the memory clock domain and are handed to the system clock domain through a small FIFO. Write and read pointers cross between the two clocks as gray codes through two-flop synchronizers. Each status flag is computed in the clock domain that uses it.

A static configuration input sets the storage as a single 16-word FIFO or as two independent 8-word FIFOs. In the split setting a write-side bank select and a read-side bank select choose the half that each port uses. The empty, half-full and full flags are all active-low. The half-full threshold follows the configuration: eight words for the single FIFO and four words for one half.

A path select chooses the output source. It can be the FIFO's registered output, or a bypass holding stage that is transparent to the memory data while it is open and keeps its value while it is closed. The configuration input may change only while both resets are held.

Top module: `ecc_rdbuf`

## Requirements
- R1: While both resets are low and after they are released with no traffic, empty_n is 0, half_n is 1, full_n is 1, and rdata is all zeros with path_sel at 1.
- R2: On a rising mclk edge with wr_n low and the selected FIFO not full, mdata is stored. Words leave each FIFO in the order they were written.
- R3: On a rising sclk edge with rd_n low and the selected FIFO not empty, the oldest word is loaded into the output register and shows on rdata when path_sel is 1. With rd_n high, rdata holds its value.
- R4: With split_mode at 0, half_n is 0 when the FIFO holds 8 or more words and 1 when it holds 7 or fewer.
- R5: With split_mode at 1, half_n is 0 when the read-selected half holds 4 or more words and 1 when it holds 3 or fewer.
- R6: full_n is 0 exactly when the write-selected FIFO holds its capacity (16 words with split_mode 0, 8 words with split_mode 1). empty_n is 0 exactly when the read-selected FIFO holds no word.
- R7: A write while full_n is 0 stores nothing and leaves the FIFO's contents and order unchanged.
- R8: A read while empty_n is 0 leaves rdata unchanged and moves no pointer, so the next word written is the next word read.
- R9: With split_mode at 1, wr_bank (0 or 1) selects the half that is written and that full_n reports, and rd_bank selects the half that is read and that empty_n and half_n report. The halves do not affect each other. With split_mode at 0, both bank selects are ignored.
- R10: path_sel 1 drives rdata from the FIFO output register. path_sel 0 drives rdata from the bypass stage. While lat_open is 1, that stage passes mdata straight through and captures it on each rising mclk edge. While lat_open is 0, it holds the last value it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Memory-side clock |
| mrst_n | input | 1 | Synchronous active-low reset, mclk domain |
| sclk | input | 1 | System-side clock |
| srst_n | input | 1 | Synchronous active-low reset, sclk domain |
| split_mode | input | 1 | 0: one 16-word FIFO; 1: two 8-word FIFOs (static) |
| wr_bank | input | 1 | Write half select in split mode |
| wr_n | input | 1 | Active-low write request, mclk domain |
| mdata | input | 64 | Corrected memory word |
| lat_open | input | 1 | Bypass stage open (transparent) when 1 |
| rd_bank | input | 1 | Read half select in split mode |
| rd_n | input | 1 | Active-low read request, sclk domain |
| path_sel | input | 1 | 1: FIFO output; 0: bypass stage |
| rdata | output | 64 | Output word |
| empty_n | output | 1 | Active-low empty flag, sclk domain |
| half_n | output | 1 | Active-low half-full flag, sclk domain |
| full_n | output | 1 | Active-low full flag, mclk domain |

## Verification
The bench walks the single FIFO through the 7/8 half-full boundary and up to 16 words. It then switches to split mode and checks the 3/4 boundary and the 8-word cap. A threshold off by one would show the half-full flag one word early or late, and a capacity that ignored the mode would let a ninth word into a half. Writes to a full FIFO and reads from an empty one are followed by reads of the real data: a corrupted pointer would return a stale or skipped word. Bank-select tests catch flags taken from the wrong half, and also bank selects that wrongly act in single mode. The bypass checks catch a stage that is not transparent while open, or that keeps following mdata after it closes.

// File: rtl/ecc_rdbuf_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the dual-clock read buffer.
// Assumes pointer widths never exceed PTR_MAX bits; callers zero-extend
// narrower pointers, which leaves both conversions exact.
package ecc_rdbuf_pkg;
    localparam int PTR_MAX = 16;

    // Binary to reflected gray code.
    function automatic logic [PTR_MAX-1:0] bin_to_gray(input logic [PTR_MAX-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected gray code back to binary.
    function automatic logic [PTR_MAX-1:0] gray_to_bin(input logic [PTR_MAX-1:0] g);
        logic [PTR_MAX-1:0] b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/ecc_rdbuf_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a pair of gray-coded pointers.
// Assumes each pointer changes by at most one bit per source clock.
module ecc_rdbuf_sync2 #(
    parameter int W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0][W-1:0] d,
    output logic [1:0][W-1:0] q
);
    logic [1:0][W-1:0] meta_q;

    // Two register stages in the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/ecc_rdbuf_wr_side.sv
`timescale 1ns/1ps
// Write port of the read buffer (mclk domain).
// Keeps one binary and one gray pointer per bank. It computes full_n for
// the write-selected bank from the synchronized read pointer and produces
// the storage write address. Assumes split is static while out of reset.
module ecc_rdbuf_wr_side
    import ecc_rdbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic               mclk,
    input  logic               mrst_n,
    input  logic               split,
    input  logic               wbank,
    input  logic               wr_n,
    input  logic [1:0][PW-1:0] rgray_s,
    output logic [1:0][PW-1:0] wgray,
    output logic [AW-1:0]      waddr,
    output logic               we,
    output logic               full_n
);
    logic [1:0][PW-1:0] wbin_q;
    logic               bsel;
    logic [PW-1:0]      rbin_s;
    logic [PW-1:0]      used;
    logic [PW-1:0]      cap;

    assign bsel   = split & wbank;
    assign rbin_s = PW'(gray_to_bin(PTR_MAX'(rgray_s[bsel])));
    assign used   = wbin_q[bsel] - rbin_s;
    assign cap    = split ? PW'(DEPTH / 2) : PW'(DEPTH);
    assign full_n = (used != cap);
    assign we     = ~wr_n & full_n;
    assign waddr  = split ? {bsel, wbin_q[bsel][AW-2:0]} : wbin_q[bsel][AW-1:0];

    // Advance the selected bank's pointers on an accepted write.
    always_ff @(posedge mclk) begin
        if (!mrst_n) begin
            wbin_q <= '0;
            wgray  <= '0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (we && bsel == 1'(b)) begin
                    wbin_q[b] <= wbin_q[b] + 1'b1;
                    wgray[b]  <= PW'(bin_to_gray(PTR_MAX'(wbin_q[b] + 1'b1)));
                end
            end
        end
    end

    // R6: the write-side view of occupancy never passes capacity.
    a_r6_no_overflow: assert property (@(posedge mclk) disable iff (!mrst_n)
        used <= cap);

    for (genvar gb = 0; gb < 2; gb++) begin : g_bank_chk
        // R7: a write refused while full leaves the pointer alone.
        a_r7_full_holds_ptr: assert property (@(posedge mclk) disable iff (!mrst_n)
            (!wr_n && bsel == 1'(gb) && !full_n) |=> $stable(wbin_q[gb]));
        // R2: the crossing pointer moves by at most one bit per edge.
        a_r2_gray_one_step: assert property (@(posedge mclk) disable iff (!mrst_n)
            $countones(wgray[gb] ^ $past(wgray[gb])) <= 1);
    end
endmodule

// File: rtl/ecc_rdbuf_rd_side.sv
`timescale 1ns/1ps
// Read port of the read buffer (sclk domain).
// Keeps one binary and one gray pointer per bank. It computes empty_n and
// half_n for the read-selected bank from the synchronized write pointer and
// produces the storage read address. Assumes split is static out of reset.
module ecc_rdbuf_rd_side
    import ecc_rdbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic               sclk,
    input  logic               srst_n,
    input  logic               split,
    input  logic               rbank,
    input  logic               rd_n,
    input  logic [1:0][PW-1:0] wgray_s,
    output logic [1:0][PW-1:0] rgray,
    output logic [AW-1:0]      raddr,
    output logic               re,
    output logic               empty_n,
    output logic               half_n
);
    logic [1:0][PW-1:0] rbin_q;
    logic               bsel;
    logic [PW-1:0]      wbin_s;
    logic [PW-1:0]      used;
    logic [PW-1:0]      thr;

    assign bsel    = split & rbank;
    assign wbin_s  = PW'(gray_to_bin(PTR_MAX'(wgray_s[bsel])));
    assign used    = wbin_s - rbin_q[bsel];
    assign thr     = split ? PW'(DEPTH / 4) : PW'(DEPTH / 2);
    assign empty_n = (used != '0);
    assign half_n  = ~(used >= thr);
    assign re      = ~rd_n & empty_n;
    assign raddr   = split ? {bsel, rbin_q[bsel][AW-2:0]} : rbin_q[bsel][AW-1:0];

    // Advance the selected bank's pointers on an accepted read.
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            rbin_q <= '0;
            rgray  <= '0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (re && bsel == 1'(b)) begin
                    rbin_q[b] <= rbin_q[b] + 1'b1;
                    rgray[b]  <= PW'(bin_to_gray(PTR_MAX'(rbin_q[b] + 1'b1)));
                end
            end
        end
    end

    // R4: half-full can only be reported when data is present.
    a_r4_half_needs_data: assert property (@(posedge sclk) disable iff (!srst_n)
        !half_n |-> empty_n);

    for (genvar gb = 0; gb < 2; gb++) begin : g_bank_chk
        // R8: a read refused while empty leaves the pointer alone.
        a_r8_empty_holds_ptr: assert property (@(posedge sclk) disable iff (!srst_n)
            (!rd_n && bsel == 1'(gb) && !empty_n) |=> $stable(rbin_q[gb]));
        // R2: the crossing pointer moves by at most one bit per edge.
        a_r2_rgray_one_step: assert property (@(posedge sclk) disable iff (!srst_n)
            $countones(rgray[gb] ^ $past(rgray[gb])) <= 1);
    end
endmodule

// File: rtl/ecc_rdbuf_store.sv
`timescale 1ns/1ps
// Word storage with a registered read port.
// Written in mclk, read in sclk. Assumes the pointer logic never reads a
// slot that is still being written, so the crossing read is safe.
module ecc_rdbuf_store #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              mclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sclk,
    input  logic              srst_n,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store an accepted word.
    always_ff @(posedge mclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Load the output register on an accepted read.
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            q <= '0;
        end else if (re) begin
            q <= mem[raddr];
        end
    end

    // R3: the output register changes only on an accepted read.
    a_r3_out_holds: assert property (@(posedge sclk) disable iff (!srst_n)
        !re |=> $stable(q));
endmodule

// File: rtl/ecc_rdbuf_bypass.sv
`timescale 1ns/1ps
// Bypass holding stage: transparent while open, holding while closed.
// Built from a flop plus a mux so that no level-sensitive storage appears;
// the held value is the one captured on the last mclk edge while open.
module ecc_rdbuf_bypass #(
    parameter int DATA_W = 64
) (
    input  logic              mclk,
    input  logic              mrst_n,
    input  logic              open,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] y
);
    logic [DATA_W-1:0] hold_q;

    // Capture the memory word on every edge while open.
    always_ff @(posedge mclk) begin
        if (!mrst_n) begin
            hold_q <= '0;
        end else if (open) begin
            hold_q <= d;
        end
    end

    assign y = open ? d : hold_q;

    // R10: a closed stage keeps its held word.
    a_r10_closed_holds: assert property (@(posedge mclk) disable iff (!mrst_n)
        !open |=> $stable(hold_q));
endmodule

// File: rtl/ecc_rdbuf.sv
`timescale 1ns/1ps
// Dual-clock read buffer with bypass, top level.
// Memory-side writes on mclk, system-side reads on sclk. Storage is one
// 16-word FIFO or two 8-word halves (split_mode, static while out of
// reset). Gray pointers cross through two-flop synchronizers. rdata comes
// from the FIFO register or the bypass stage according to path_sel.
module ecc_rdbuf #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 16
) (
    input  logic              mclk,
    input  logic              mrst_n,
    input  logic              sclk,
    input  logic              srst_n,
    input  logic              split_mode,
    input  logic              wr_bank,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] mdata,
    input  logic              lat_open,
    input  logic              rd_bank,
    input  logic              rd_n,
    input  logic              path_sel,
    output logic [DATA_W-1:0] rdata,
    output logic              empty_n,
    output logic              half_n,
    output logic              full_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [1:0][PW-1:0] wgray, wgray_s, rgray, rgray_s;
    logic [AW-1:0]      waddr, raddr;
    logic               we, re;
    logic [DATA_W-1:0]  fifo_q, byp_q;

    ecc_rdbuf_wr_side #(.DEPTH(DEPTH)) u_wr (
        .mclk(mclk), .mrst_n(mrst_n), .split(split_mode), .wbank(wr_bank),
        .wr_n(wr_n), .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr),
        .we(we), .full_n(full_n)
    );

    ecc_rdbuf_sync2 #(.W(PW)) u_w2r (
        .clk(sclk), .rst_n(srst_n), .d(wgray), .q(wgray_s)
    );

    ecc_rdbuf_sync2 #(.W(PW)) u_r2w (
        .clk(mclk), .rst_n(mrst_n), .d(rgray), .q(rgray_s)
    );

    ecc_rdbuf_rd_side #(.DEPTH(DEPTH)) u_rd (
        .sclk(sclk), .srst_n(srst_n), .split(split_mode), .rbank(rd_bank),
        .rd_n(rd_n), .wgray_s(wgray_s), .rgray(rgray), .raddr(raddr),
        .re(re), .empty_n(empty_n), .half_n(half_n)
    );

    ecc_rdbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .mclk(mclk), .we(we), .waddr(waddr), .wdata(mdata),
        .sclk(sclk), .srst_n(srst_n), .re(re), .raddr(raddr), .q(fifo_q)
    );

    ecc_rdbuf_bypass #(.DATA_W(DATA_W)) u_byp (
        .mclk(mclk), .mrst_n(mrst_n), .open(lat_open), .d(mdata), .y(byp_q)
    );

    assign rdata = path_sel ? fifo_q : byp_q;

    // R1: an empty buffer never reports half-full.
    a_r1_empty_not_half: assert property (@(posedge sclk) disable iff (!srst_n)
        !empty_n |-> half_n);
endmodule

// File: tb/ecc_rdbuf_bench.sv
`timescale 1ns/1ps
// Self-checking bench for ecc_rdbuf: a vector table for single-FIFO
// occupancy, then directed tests for split mode, banks, limits and bypass.
module ecc_rdbuf_bench;
    logic        mclk = 1'b0, sclk = 1'b0;
    logic        mrst_n, srst_n, split_mode, wr_bank, wr_n, lat_open;
    logic        rd_bank, rd_n, path_sel;
    logic [63:0] mdata, rdata;
    logic        empty_n, half_n, full_n;

    int          nchk = 0, nfail = 0;
    int          wseq [2];
    int          rseq [2];
    int          epoch = 0;
    logic [63:0] last;

    always #2 sclk = ~sclk;
    always #3 mclk = ~mclk;

    ecc_rdbuf u_ecc_rdbuf (
        .mclk(mclk), .mrst_n(mrst_n), .sclk(sclk), .srst_n(srst_n),
        .split_mode(split_mode), .wr_bank(wr_bank), .wr_n(wr_n), .mdata(mdata),
        .lat_open(lat_open), .rd_bank(rd_bank), .rd_n(rd_n), .path_sel(path_sel),
        .rdata(rdata), .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
    );

    // Table entry: [8] 1=pop 0=push, [7:4] count, [2:0] expected {empty_n,half_n,full_n}.
    localparam logic [8:0] TBL [10] = '{
        {1'b0, 4'd1, 1'b0, 3'b111},
        {1'b0, 4'd6, 1'b0, 3'b111},
        {1'b0, 4'd1, 1'b0, 3'b101},
        {1'b1, 4'd1, 1'b0, 3'b111},
        {1'b0, 4'd9, 1'b0, 3'b100},
        {1'b0, 4'd2, 1'b0, 3'b100},
        {1'b1, 4'd8, 1'b0, 3'b101},
        {1'b1, 4'd1, 1'b0, 3'b111},
        {1'b1, 4'd7, 1'b0, 3'b011},
        {1'b1, 4'd2, 1'b0, 3'b011}
    };

    function automatic logic [63:0] pat(input int b, input int s);
        return {16'hCAFE, 8'(epoch), 8'(b), 32'(s) * 32'h9E37_79B1};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge sclk);
    endtask

    task automatic do_reset(input logic sp);
        mrst_n = 1'b0; srst_n = 1'b0; split_mode = sp;
        wr_n = 1'b1; rd_n = 1'b1; wr_bank = 1'b0; rd_bank = 1'b0;
        lat_open = 1'b0; path_sel = 1'b1; mdata = '0;
        repeat (4) @(negedge mclk);
        mrst_n = 1'b1;
        @(negedge sclk);
        srst_n = 1'b1;
        epoch++;
        wseq[0] = 0; wseq[1] = 0; rseq[0] = 0; rseq[1] = 0;
        last = '0;
        settle();
    endtask

    task automatic push(input logic b);
        int eb, cap;
        eb  = split_mode ? int'(b) : 0;
        cap = split_mode ? 8 : 16;
        @(negedge mclk);
        wr_bank = b; mdata = pat(eb, wseq[eb]); wr_n = 1'b0;
        @(negedge mclk);
        wr_n = 1'b1;
        if (wseq[eb] - rseq[eb] < cap) wseq[eb]++;
    endtask

    task automatic pop(input logic b, input string tag);
        int eb;
        logic [63:0] exp;
        eb = split_mode ? int'(b) : 0;
        @(negedge sclk);
        rd_bank = b; rd_n = 1'b0;
        @(negedge sclk);
        rd_n = 1'b1;
        if (wseq[eb] - rseq[eb] > 0) begin
            exp = pat(eb, rseq[eb]);
            rseq[eb]++;
            last = exp;
        end else begin
            exp = last;
        end
        check(tag, rdata, exp);
    endtask

    task automatic flags(input string tag, input logic [2:0] exp);
        check(tag, {61'b0, empty_n, half_n, full_n}, {61'b0, exp});
    endtask

    initial begin
        #200000;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        // R1: reset state, single FIFO.
        do_reset(1'b0);
        flags("R1 flags after reset", 3'b011);
        check("R1 rdata after reset", rdata, 64'd0);

        // R2/R3/R4/R6 table walk in single-FIFO mode, bank 0.
        for (int i = 0; i < 10; i++) begin
            logic [8:0] v;
            v = TBL[i];
            for (int k = 0; k < int'(v[7:4]); k++) begin
                if (v[8]) pop(1'b0, "R3 R2 single pop data");
                else push(1'b0);
            end
            settle();
            flags("R4 R6 table flags", v[2:0]);
            check("R3 rdata holds when idle", rdata, last);
        end

        // R9: bank selects ignored in single mode.
        do_reset(1'b0);
        push(1'b1); push(1'b1);
        settle();
        rd_bank = 1'b1; #1;
        flags("R9 single mode bank ignored flags", 3'b111);
        pop(1'b0, "R9 single mode first word");
        pop(1'b1, "R9 single mode second word");

        // R5/R6/R9/R7/R8 in split mode.
        do_reset(1'b1);
        push(1'b0); push(1'b0); push(1'b0);
        settle();
        rd_bank = 1'b0; #1;
        flags("R5 three words below threshold", 3'b111);
        push(1'b0);
        settle();
        rd_bank = 1'b0; #1;
        flags("R5 four words reach threshold", 3'b101);
        @(negedge sclk); rd_bank = 1'b1; #1;
        check("R9 other half empty", {63'b0, empty_n}, 64'd0);
        check("R9 other half not half-full", {63'b0, half_n}, 64'd1);
        push(1'b1); push(1'b1); push(1'b1);
        settle();
        rd_bank = 1'b1; #1;
        check("R9 bank1 flags", {62'b0, empty_n, half_n}, 64'd3);
        push(1'b0); push(1'b0); push(1'b0); push(1'b0);
        @(negedge mclk); wr_bank = 1'b0; #1;
        check("R6 half full at eight", {63'b0, full_n}, 64'd0);
        @(negedge mclk); wr_bank = 1'b1; #1;
        check("R9 full follows write bank", {63'b0, full_n}, 64'd1);
        push(1'b0);
        settle();
        pop(1'b1, "R9 bank1 word"); pop(1'b1, "R9 bank1 word"); pop(1'b1, "R9 bank1 word");
        pop(1'b1, "R8 read when empty holds rdata");
        push(1'b1);
        settle();
        pop(1'b1, "R8 next write is next read");
        for (int k = 0; k < 8; k++) pop(1'b0, "R7 order intact after refused write");
        settle();
        rd_bank = 1'b0; #1;
        check("R6 bank0 empty again", {63'b0, empty_n}, 64'd0);

        // R10: bypass path.
        @(negedge mclk);
        path_sel = 1'b0; lat_open = 1'b1; mdata = 64'h1234_5678_9ABC_DEF0; #1;
        check("R10 open stage transparent", rdata, 64'h1234_5678_9ABC_DEF0);
        @(negedge mclk);
        lat_open = 1'b0; mdata = 64'hFEED_FACE_0BAD_F00D; #1;
        check("R10 closed stage holds", rdata, 64'h1234_5678_9ABC_DEF0);
        repeat (3) @(negedge mclk);
        check("R10 closed stage still holds", rdata, 64'h1234_5678_9ABC_DEF0);
        path_sel = 1'b1; #1;
        check("R10 path select back to FIFO", rdata, last);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule